// File: doc/BRIEF.md
# Reloading 8-bit Timer/Event Counter

This block is an 8-bit up-counter that a host programs through a few write strobes. It has three ways to advance. It can count ticks of an internal clock divided by a power of two. It can count edges on an external input after that input is synchronized. It can also measure how long that input stays at an active level. When the count passes its maximum, the counter does not wrap to zero. It restarts from a value held in a separate preload register and raises an interrupt flag. The flag stays set until the host clears it.

The host writes a control word: the mode, the prescaler exponent, the polarity/edge bit and the run bit. It writes the preload value on a separate strobe. It reads the live count, the flag and the run state directly from output ports. In pulse-width mode the block stops by itself when the measured level ends. The count then holds the width of the pulse in prescaled ticks.

Top module: `reload_timer8`

## Requirements
- R1: Each qualified increment raises `count` by exactly one on the following clock edge, unless the count is FFh.
- R2: An increment at FFh loads `count` with the preload value instead of zero. If `pre_we` falls in that same cycle, `pre_data` is the value loaded.
- R3: Every overflow sets `irq`. `irq` stays set until `irq_clr` is pulsed. When an overflow and `irq_clr` meet in one cycle, `irq` stays set.
- R4: The divide ratio is 2 to the power of `ctl_psc` (0..7, so 1..128). A control write restarts the prescaler, and the first timer increment comes on the 2^`ctl_psc`-th clock edge after the write edge.
- R5: `ctl_mode` encodings: 00 idle (never counts, even while running), 01 event count, 10 timer, 11 pulse width.
- R6: In event mode, `ctl_edge`=0 counts rising edges and `ctl_edge`=1 counts falling edges of `ext_in`. `ext_in` passes through a two-flop synchronizer first. Prescaling does not apply in this mode.
- R7: In pulse-width mode the counter takes prescaled ticks only while the synchronized `ext_in` is at its active level (high when `ctl_edge`=0, low when 1). `running` drops by itself when that level ends, and later pulses are not counted.
- R8: A preload write while stopped also loads `count`. While running, it changes only the reload value.
- R9: While `running` is low, `count` changes only through a preload write.
- R10: After reset, `count` is 00h, `irq` is 0 and `running` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_in | input | 1 | Asynchronous external event / gate input |
| ctl_we | input | 1 | Control write strobe |
| ctl_mode | input | 2 | Mode code (see R5) |
| ctl_psc | input | 3 | Prescaler exponent |
| ctl_edge | input | 1 | Edge / active-level select |
| ctl_run | input | 1 | Run bit written on `ctl_we` |
| pre_we | input | 1 | Preload write strobe |
| pre_data | input | 8 | Preload value |
| irq_clr | input | 1 | Clear strobe for the overflow flag |
| count | output | 8 | Live counter value |
| irq | output | 1 | Overflow interrupt flag |
| running | output | 1 | Counter enable state |

## Verification
Two pairs of events can fall on the same clock edge. An overflow can coincide with a host clear of the flag, and an overflow can coincide with a preload write. The bench stops the counter, preloads FEh and runs the timer at ratio one, so the overflow lands exactly two edges after the start. It places the `irq_clr` or `pre_we` pulse on that edge. Afterwards it expects the flag to remain set and the counter to hold the freshly written value.

// File: rtl/rt_pkg.sv
package rt_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } rt_mode_e;
endpackage

// File: rtl/rt_prescaler.sv
module rt_prescaler #(
  parameter int PSC_BITS = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                restart,
  input  logic [PSC_BITS-1:0] sel,
  output logic                tick
);
  localparam int DIV_W = (1 << PSC_BITS) - 1;

  logic [DIV_W-1:0] phase_q;
  logic [DIV_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst || restart) phase_q <= '0;
    else                phase_q <= phase_q + 1'b1;
  end

  // mask has sel low ones; sel = DIV_W gives all ones
  assign mask = (DIV_W'(1) << sel) - 1'b1;
  assign tick = &(phase_q | ~mask);
endmodule

// File: rtl/rt_sync_edge.sv
module rt_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_in,
  input  logic pol,
  output logic act,
  output logic act_rise,
  output logic act_fall
);
  logic [SYNC_STAGES:0] chain_q;
  logic                 act_prev;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[SYNC_STAGES-1:0], ext_in};
  end

  assign act      = chain_q[SYNC_STAGES-1] ^ pol;
  assign act_prev = chain_q[SYNC_STAGES] ^ pol;
  assign act_rise = act & ~act_prev;
  assign act_fall = ~act & act_prev;
endmodule

// File: rtl/rt_count_core.sv
module rt_count_core
  import rt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  rt_mode_e         mode,
  input  logic             tick,
  input  logic             act,
  input  logic             act_rise,
  input  logic             act_fall,
  input  logic             ctl_we,
  input  logic             ctl_run,
  input  logic             pre_we,
  input  logic [WIDTH-1:0] pre_data,
  input  logic             irq_clr,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] preload,
  output logic             irq,
  output logic             running,
  output logic             inc,
  output logic             ovf
);
  localparam logic [WIDTH-1:0] CNT_MAX = '1;

  logic             step;
  logic [WIDTH-1:0] reload_val;

  always_comb begin
    unique case (mode)
      MODE_EVENT: step = act_rise;
      MODE_TIMER: step = tick;
      MODE_PULSE: step = tick & act;
      default:    step = 1'b0;
    endcase
  end

  assign inc        = running & step;
  assign ovf        = inc & (count == CNT_MAX);
  assign reload_val = pre_we ? pre_data : preload;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      preload <= '0;
      count   <= '0;
      irq     <= 1'b0;
    end else begin
      if (ctl_we)
        running <= ctl_run;
      else if (mode == MODE_PULSE && running && act_fall)
        running <= 1'b0;

      if (pre_we) preload <= pre_data;

      if (pre_we && !running) count <= pre_data;
      else if (ovf)           count <= reload_val;
      else if (inc)           count <= count + 1'b1;

      if (ovf)          irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/reload_timer8.sv
module reload_timer8
  import rt_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int PSC_BITS    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ext_in,
  input  logic                ctl_we,
  input  logic [1:0]          ctl_mode,
  input  logic [PSC_BITS-1:0] ctl_psc,
  input  logic                ctl_edge,
  input  logic                ctl_run,
  input  logic                pre_we,
  input  logic [WIDTH-1:0]    pre_data,
  input  logic                irq_clr,
  output logic [WIDTH-1:0]    count,
  output logic                irq,
  output logic                running
);
  rt_mode_e            mode_q;
  logic [PSC_BITS-1:0] psc_q;
  logic                pol_q;
  logic                tick_w, act_w, act_rise_w, act_fall_w;
  logic                inc_w, ovf_w;
  logic [WIDTH-1:0]    preload_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_IDLE;
      psc_q  <= '0;
      pol_q  <= 1'b0;
    end else if (ctl_we) begin
      mode_q <= rt_mode_e'(ctl_mode);
      psc_q  <= ctl_psc;
      pol_q  <= ctl_edge;
    end
  end

  rt_prescaler #(.PSC_BITS(PSC_BITS)) u_psc (
    .clk(clk), .rst(rst), .restart(ctl_we), .sel(psc_q), .tick(tick_w)
  );

  rt_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .ext_in(ext_in), .pol(pol_q),
    .act(act_w), .act_rise(act_rise_w), .act_fall(act_fall_w)
  );

  rt_count_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst(rst), .mode(mode_q), .tick(tick_w),
    .act(act_w), .act_rise(act_rise_w), .act_fall(act_fall_w),
    .ctl_we(ctl_we), .ctl_run(ctl_run),
    .pre_we(pre_we), .pre_data(pre_data), .irq_clr(irq_clr),
    .count(count), .preload(preload_w), .irq(irq), .running(running),
    .inc(inc_w), .ovf(ovf_w)
  );
endmodule

// File: rtl/rt_checker.sv
module rt_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] count,
  input logic [WIDTH-1:0] preload,
  input logic [WIDTH-1:0] pre_data,
  input logic             pre_we,
  input logic             irq,
  input logic             irq_clr,
  input logic             running,
  input logic             ctl_we,
  input logic [1:0]       mode,
  input logic             inc,
  input logic             ovf,
  input logic             act_fall
);
  a_r1_step: assert property (@(posedge clk) disable iff (rst)
    (inc && !ovf && !(pre_we && !running)) |=> count == $past(count) + 1'b1);

  a_r2_reload: assert property (@(posedge clk) disable iff (rst)
    ovf |=> count == ($past(pre_we) ? $past(pre_data) : $past(preload)));

  a_r3_irq_set: assert property (@(posedge clk) disable iff (rst)
    ovf |=> irq);

  a_r3_irq_hold: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);

  a_r5_idle: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |-> !inc);

  a_r7_self_stop: assert property (@(posedge clk) disable iff (rst)
    (running && mode == 2'b11 && act_fall && !ctl_we) |=> !running);

  a_r8_direct_load: assert property (@(posedge clk) disable iff (rst)
    (pre_we && !running) |=> count == $past(pre_data));

  a_r9_stopped: assert property (@(posedge clk) disable iff (rst)
    (!running && !pre_we) |=> $stable(count));
endmodule

bind reload_timer8 rt_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .count(count), .preload(preload_w),
  .pre_data(pre_data), .pre_we(pre_we), .irq(irq), .irq_clr(irq_clr),
  .running(running), .ctl_we(ctl_we), .mode(mode_q),
  .inc(inc_w), .ovf(ovf_w), .act_fall(act_fall_w)
);

// File: tb/test_reload_timer8.sv
module test_reload_timer8;
  logic       clk = 1'b0;
  logic       rst, ext_in, ctl_we, ctl_edge, ctl_run, pre_we, irq_clr;
  logic [1:0] ctl_mode;
  logic [2:0] ctl_psc;
  logic [7:0] pre_data, count;
  logic       irq, running;
  int         checks = 0, errors = 0;

  always #5 clk = ~clk;

  reload_timer8 i_reload_timer8 (
    .clk(clk), .rst(rst), .ext_in(ext_in), .ctl_we(ctl_we),
    .ctl_mode(ctl_mode), .ctl_psc(ctl_psc), .ctl_edge(ctl_edge),
    .ctl_run(ctl_run), .pre_we(pre_we), .pre_data(pre_data),
    .irq_clr(irq_clr), .count(count), .irq(irq), .running(running)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl_write(input logic [1:0] m, input logic [2:0] p,
                           input logic e, input logic r);
    ctl_mode = m; ctl_psc = p; ctl_edge = e; ctl_run = r; ctl_we = 1'b1;
    step(1);
    ctl_we = 1'b0;
  endtask

  task automatic pre_write(input logic [7:0] v);
    pre_data = v; pre_we = 1'b1;
    step(1);
    pre_we = 1'b0;
  endtask

  task automatic clear_irq();
    irq_clr = 1'b1;
    step(1);
    irq_clr = 1'b0;
  endtask

  // expected {irq, count} after k edges of timer mode at ratio n
  function automatic logic [8:0] timer_model(input logic [7:0] start,
      input logic [7:0] pre, input int n, input int k);
    logic [7:0] c = start;
    logic       f = 1'b0;
    for (int e = 1; e <= k; e++) begin
      if (e % n == 0) begin
        if (c == 8'hFF) begin c = pre; f = 1'b1; end
        else c = c + 8'd1;
      end
    end
    return {f, c};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] base, pv;
    logic [8:0] expv;
    int         psc, k;
    void'($urandom(32'h0000_5eed));
    rst = 1'b1; ext_in = 1'b0; ctl_we = 1'b0; ctl_mode = 2'b00; ctl_psc = 3'd0;
    ctl_edge = 1'b0; ctl_run = 1'b0; pre_we = 1'b0; pre_data = 8'h00; irq_clr = 1'b0;
    step(3);
    rst = 1'b0;
    step(1);
    chk("R10 count", count, 0);
    chk("R10 irq", irq, 0);
    chk("R10 running", running, 0);

    // R8: load while stopped, R9: stopped holds
    pre_write(8'h3C);
    chk("R8 direct load", count, 8'h3C);
    ctl_write(2'b10, 3'd0, 1'b0, 1'b0);
    step(10);
    chk("R9 stopped", count, 8'h3C);

    // R5: idle mode never counts
    ctl_write(2'b00, 3'd0, 1'b0, 1'b1);
    step(10);
    chk("R5 idle", count, 8'h3C);
    ctl_write(2'b00, 3'd0, 1'b0, 1'b0);

    // R1 R2 R3: overflow reloads and sets irq
    pre_write(8'hFE);
    ctl_write(2'b10, 3'd0, 1'b0, 1'b1);
    step(1);
    chk("R1 step", count, 8'hFF);
    step(1);
    chk("R2 reload", count, 8'hFE);
    chk("R3 irq set", irq, 1);
    step(4);
    chk("R3 irq held", irq, 1);

    // R3: clear coinciding with overflow keeps flag; later clear works
    ctl_write(2'b10, 3'd0, 1'b0, 1'b0);
    clear_irq();
    chk("R3 cleared", irq, 0);
    pre_write(8'hFE);
    ctl_write(2'b10, 3'd0, 1'b0, 1'b1);
    step(1);
    irq_clr = 1'b1;
    step(1);
    irq_clr = 1'b0;
    chk("R3 set wins", irq, 1);
    clear_irq();
    chk("R3 plain clear", irq, 0);

    // R2: preload write coinciding with overflow supplies the new value
    ctl_write(2'b10, 3'd0, 1'b0, 1'b0);
    pre_write(8'hFE);
    ctl_write(2'b10, 3'd0, 1'b0, 1'b1);
    step(1);
    pre_write(8'h10);
    chk("R2 same-cycle reload", count, 8'h10);
    step(3);
    chk("R8 running write no load", count, 8'h13);

    // R4 R1 R2 R3: random timer runs
    for (int it = 0; it < 8; it++) begin
      ctl_write(2'b10, 3'd0, 1'b0, 1'b0);
      clear_irq();
      base = 8'($urandom_range(0, 255));
      pv   = 8'($urandom_range(0, 255));
      psc  = $urandom_range(0, 4);
      k    = $urandom_range(1, 300);
      pre_write(base);
      pre_write(pv);
      chk("R8 load", count, pv);
      ctl_write(2'b10, 3'(psc), 1'b0, 1'b1);
      step(k);
      expv = timer_model(pv, pv, 1 << psc, k);
      chk("R4 count", count, expv[7:0]);
      chk("R3 flag", irq, expv[8]);
    end

    // R4: exact phase of first increment at ratio 8
    ctl_write(2'b10, 3'd0, 1'b0, 1'b0);
    pre_write(8'h40);
    ctl_write(2'b10, 3'd3, 1'b0, 1'b1);
    step(7);
    chk("R4 before tick", count, 8'h40);
    step(1);
    chk("R4 on tick", count, 8'h41);

    // R6: rising and falling event counting
    for (int pol = 0; pol < 2; pol++) begin
      ctl_write(2'b01, 3'd5, 1'b0, 1'b0);
      ext_in = 1'b0;
      pre_write(8'h20);
      step(4);
      ctl_write(2'b01, 3'd5, 1'(pol), 1'b1);
      for (int p = 0; p < 3; p++) begin
        ext_in = 1'b1; step(3);
        ext_in = 1'b0; step(3);
      end
      ext_in = 1'b1;
      step(6);
      chk(pol ? "R6 falling" : "R6 rising", count, pol ? 8'h23 : 8'h24);
    end

    // R7: pulse width measurement and self stop
    ctl_write(2'b11, 3'd0, 1'b0, 1'b0);
    ext_in = 1'b0;
    pre_write(8'h05);
    step(4);
    ctl_write(2'b11, 3'd0, 1'b0, 1'b1);
    step(5);
    chk("R7 inactive level", count, 8'h05);
    ext_in = 1'b1; step(7);
    ext_in = 1'b0; step(6);
    chk("R7 width", count, 8'h0C);
    chk("R7 self stop", running, 0);
    ext_in = 1'b1; step(5);
    ext_in = 1'b0; step(6);
    chk("R7 later pulse ignored", count, 8'h0C);

    // R7: active-low pulse
    ext_in = 1'b1;
    pre_write(8'h00);
    step(4);
    ctl_write(2'b11, 3'd0, 1'b1, 1'b1);
    ext_in = 1'b0; step(4);
    ext_in = 1'b1; step(6);
    chk("R7 low width", count, 8'h04);
    chk("R7 low self stop", running, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule